// File: doc/BRIEF.md
# Two-User Interprocessor Mailbox

This block lets two processors pass 32-bit words to each other through a small register port. It holds two mailboxes, and each one is a first-in first-out queue four words deep. Mailbox m carries traffic towards user (m+1) mod 2. Either user may write a message into a mailbox. Only the receiving user removes a word by reading the message register. Software can also read a per-mailbox full flag and a per-mailbox message count. A sender that wants to post several words uses the count to check for room first.

Each user has its own interrupt enable register and its own interrupt status register. For mailbox m, bit 2m flags a newly queued message, and bit 2m+1 flags that a full queue has just had a word removed. Event bits latch in both users' status registers whatever the enables hold. The enables only mask which latched bits drive that user's level interrupt. A sender facing a full queue can therefore enable the not-full bit and wait, with no need to poll.

The register port has no back-pressure and accepts one access in every cycle that `bus_valid` is high. A read returns its word on `rsp_data` with `rsp_valid` high exactly one cycle later. Writes produce no response. The port identifies the issuing user on `bus_user`, which selects that user's enable and status registers. Register addresses are 0/1 for the message registers of mailbox 0/1, 2/3 for full status, 4/5 for count, 6 for interrupt enable and 7 for interrupt status.

Top module: `mbx_ipc_top`

## Requirements
- R1: Words written to message address m come out in write order when the receiving user (user (m+1) mod 2) reads address m. Every read returns its data with `rsp_valid` high on the cycle after the request.
- R2: Reading address 2+m returns 1 in bit 0 exactly when mailbox m holds 4 words, and returns 0 when at least one slot is free. All other bits read 0.
- R3: Reading address 4+m returns the number of queued words (0 to 4) in bits [2:0], and 0 in all other bits.
- R4: A write to a full mailbox is discarded. The count stays at 4 and the queued words are unchanged.
- R5: A message read from an empty mailbox returns 0 and leaves the count at 0. A message read by the sending user (the non-receiver) returns 0 and removes nothing.
- R6: Each successful enqueue into mailbox m sets bit 2m in both users' status registers, whatever the enables hold.
- R7: A receiver read that removes a word from a full mailbox m sets bit 2m+1 in both users' status registers.
- R8: Writing address 7 clears each of the issuing user's status bits whose write-data bit is 1. Bits written 0 are unchanged. Address 6 is read and written directly as the issuing user's enable register (bits [3:0]).
- R9: `irq[u]` is high exactly when some status bit of user u is set and its enable bit is also set.
- R10: After reset all queues are empty, and all counts, full flags, enables, status bits and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | Issuing user (0 or 1) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | DATA_W | Read data |
| irq | output | 2 | Level interrupt per user |

## Verification
Mailbox 0 is filled to capacity and then written once more. It is then drained one word past empty. The drained words show that the overflow word was dropped and not written over the newest entry, and the final read separates a correct empty read from a stale head. A read by the sending user while the queue is full tells a receiver check apart from an unchecked dequeue. A later partial drain and refill forces both pointers to wrap, which exposes ordering faults that a single fill never shows. Traffic in the opposite direction on mailbox 1 confirms that its events land on bit 2 and not on the mailbox 0 bits. With different enables per user, each latched event must raise one user's interrupt and stay masked for the other.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_USER = 2;
  localparam int NUM_MBOX = 2;
  localparam int EV_W     = 2 * NUM_MBOX;
  localparam int ADDR_W   = 3;
  localparam int USER_W   = 1;

  localparam int ADR_MSG_BASE  = 0;
  localparam int ADR_FULL_BASE = 2;
  localparam int ADR_CNT_BASE  = 4;
  localparam int ADR_IRQ_EN    = 6;
  localparam int ADR_IRQ_ST    = 7;

  function automatic int receiver_of(input int m);
    return (m + 1) % NUM_USER;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              push_req,
  input  logic [DATA_W-1:0]                 push_data,
  input  logic                              pop_req,
  output logic [DATA_W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]        count,
  output logic                              full,
  output logic                              empty,
  output logic                              push_done,
  output logic                              pop_from_full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full          = (count == CNT_W'(DEPTH));
  assign empty         = (count == '0);
  assign push_ok       = push_req && !full;
  assign pop_ok        = pop_req && !empty;
  assign push_done     = push_ok;
  assign pop_from_full = pop_ok && full;
  assign head          = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
  parameter int EV_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic            st_w1c,
  input  logic [EV_W-1:0] wdata,
  input  logic [EV_W-1:0] event_set,
  output logic [EV_W-1:0] enable,
  output logic [EV_W-1:0] status,
  output logic            irq
);
  logic [EV_W-1:0] clr_mask;

  assign clr_mask = st_w1c ? wdata : '0;
  assign irq      = |(status & enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= '0;
      status <= '0;
    end else begin
      if (en_we) enable <= wdata;
      status <= (status & ~clr_mask) | event_set;
    end
  end
endmodule

// File: rtl/mbx_ipc_top.sv
module mbx_ipc_top
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic                bus_user,
  input  logic [2:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [1:0]          irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic rd_req, wr_req;
  logic [NUM_MBOX-1:0]             push_req, pop_req, mb_full, mb_empty, push_done, pop_ff;
  logic [NUM_MBOX-1:0][DATA_W-1:0] mb_head;
  logic [NUM_MBOX-1:0][CNT_W-1:0]  mb_count;
  logic [EV_W-1:0]                 evt;
  logic [NUM_USER-1:0][EV_W-1:0]   irq_en, irq_st;
  logic [DATA_W-1:0]               rd_word;

  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid && bus_write;

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
    assign push_req[m] = wr_req && (bus_addr == ADDR_W'(ADR_MSG_BASE + m));
    assign pop_req[m]  = rd_req && (bus_addr == ADDR_W'(ADR_MSG_BASE + m))
                         && (bus_user == USER_W'(receiver_of(m)));

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk           (clk),
      .rst_n         (rst_n),
      .push_req      (push_req[m]),
      .push_data     (bus_wdata),
      .pop_req       (pop_req[m]),
      .head          (mb_head[m]),
      .count         (mb_count[m]),
      .full          (mb_full[m]),
      .empty         (mb_empty[m]),
      .push_done     (push_done[m]),
      .pop_from_full (pop_ff[m])
    );

    assign evt[2*m]   = push_done[m];
    assign evt[2*m+1] = pop_ff[m];
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    logic en_we, st_w1c;
    assign en_we  = wr_req && (bus_user == USER_W'(u)) && (bus_addr == ADDR_W'(ADR_IRQ_EN));
    assign st_w1c = wr_req && (bus_user == USER_W'(u)) && (bus_addr == ADDR_W'(ADR_IRQ_ST));

    mbx_irq_bank #(.EV_W(EV_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_we     (en_we),
      .st_w1c    (st_w1c),
      .wdata     (bus_wdata[EV_W-1:0]),
      .event_set (evt),
      .enable    (irq_en[u]),
      .status    (irq_st[u]),
      .irq       (irq[u])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int m = 0; m < NUM_MBOX; m++) begin
      if (bus_addr == ADDR_W'(ADR_MSG_BASE + m) && pop_req[m] && !mb_empty[m])
        rd_word = mb_head[m];
      if (bus_addr == ADDR_W'(ADR_FULL_BASE + m))
        rd_word[0] = mb_full[m];
      if (bus_addr == ADDR_W'(ADR_CNT_BASE + m))
        rd_word[CNT_W-1:0] = mb_count[m];
    end
    if (bus_addr == ADDR_W'(ADR_IRQ_EN)) rd_word[EV_W-1:0] = irq_en[bus_user];
    if (bus_addr == ADDR_W'(ADR_IRQ_ST)) rd_word[EV_W-1:0] = irq_st[bus_user];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_data  <= rd_req ? rd_word : '0;
    end
  end
endmodule

// File: rtl/mbx_ipc_chk.sv
module mbx_ipc_chk
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      bus_valid,
  input logic                                      bus_write,
  input logic                                      bus_user,
  input logic [2:0]                                bus_addr,
  input logic [DATA_W-1:0]                         bus_wdata,
  input logic [NUM_MBOX-1:0][$clog2(DEPTH+1)-1:0]  mb_count,
  input logic [NUM_MBOX-1:0]                       mb_full,
  input logic [NUM_USER-1:0][EV_W-1:0]             irq_en,
  input logic [NUM_USER-1:0][EV_W-1:0]             irq_st,
  input logic                                      rsp_valid,
  input logic [DATA_W-1:0]                         rsp_data,
  input logic [1:0]                                irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && !bus_write) |=> rsp_valid); // R1

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_m
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) mb_count[m] <= CNT_W'(DEPTH)); // R3
    AST_FULL_READ: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && !bus_write && bus_addr == 3'(ADR_FULL_BASE + m)) |=> (rsp_data[0] == $past(mb_count[m] == CNT_W'(DEPTH)))); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && bus_write && bus_addr == 3'(ADR_MSG_BASE + m) && mb_full[m]) |=> $stable(mb_count[m])); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && !bus_write && bus_addr == 3'(ADR_MSG_BASE + m) && mb_count[m] == '0) |=> (rsp_data == '0 && mb_count[m] == '0)); // R5
    for (genvar u = 0; u < NUM_USER; u++) begin : g_u
      AST_NEWMSG_SET: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && bus_write && bus_addr == 3'(ADR_MSG_BASE + m) && !mb_full[m]) |=> irq_st[u][2*m]); // R6
      AST_NOTFULL_SET: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && !bus_write && bus_addr == 3'(ADR_MSG_BASE + m) && bus_user == 1'(receiver_of(m)) && mb_full[m]) |=> irq_st[u][2*m+1]); // R7
    end
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_usr
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) ((irq_en[u] & irq_st[u]) == '0) |-> !irq[u]); // R9
    for (genvar b = 0; b < EV_W; b++) begin : g_b
      AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && bus_write && bus_user == 1'(u) && bus_addr == 3'(ADR_IRQ_ST) && bus_wdata[b]) |=> !irq_st[u][b]); // R8
    end
  end
endmodule

bind mbx_ipc_top mbx_ipc_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_user  (bus_user),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mb_count  (mb_count),
  .mb_full   (mb_full),
  .irq_en    (irq_en),
  .irq_st    (irq_st),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .irq       (irq)
);

// File: tb/mbx_ipc_top_tb.sv
module mbx_ipc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_user = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  mbx_ipc_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_user(bus_user), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );

  // monitor: compares each read response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic wr(input logic u, input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_user = u; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic u, input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_valid = 1'b1; bus_write = 1'b0; bus_user = u; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(irq[0], 1'b0, "R10 irq0");
    chk(irq[1], 1'b0, "R10 irq1");
    rd(0, 3'd4, 0, "R10 count mb0");
    rd(0, 3'd3, 0, "R10 full mb1");
    rd(0, 3'd7, 0, "R10 status u0");
    rd(1, 3'd6, 0, "R10 enable u1");
    // enables: user1 new-msg mb0, user0 not-full mb0 + new-msg mb1
    wr(1, 3'd6, 32'h1);
    wr(0, 3'd6, 32'h6);
    rd(0, 3'd6, 32'h6, "R8 enable readback");
    // first message
    wr(0, 3'd0, 32'hA0A0_0001);
    chk(irq[1], 1'b1, "R9 irq1 on new msg");
    chk(irq[0], 1'b0, "R9 irq0 masked");
    rd(0, 3'd7, 32'h1, "R6 status u0 latched");
    rd(1, 3'd7, 32'h1, "R6 status u1");
    rd(0, 3'd4, 1, "R3 count one");
    // fill and overflow
    wr(0, 3'd0, 32'hB0B0_0002);
    wr(0, 3'd0, 32'hC0C0_0003);
    wr(0, 3'd0, 32'hD0D0_0004);
    rd(0, 3'd4, 4, "R3 count full");
    rd(0, 3'd2, 1, "R2 full flag set");
    wr(0, 3'd0, 32'hEEEE_EEEE);
    rd(0, 3'd4, 4, "R4 count after overflow");
    // W1C
    wr(1, 3'd7, 32'h0);
    rd(1, 3'd7, 32'h1, "R8 write zero keeps");
    wr(1, 3'd7, 32'h1);
    chk(irq[1], 1'b0, "R8 irq1 after clear");
    rd(1, 3'd7, 32'h0, "R8 cleared");
    // sender read
    rd(0, 3'd0, 32'h0, "R5 sender read");
    rd(0, 3'd4, 4, "R5 sender no dequeue");
    chk(irq[0], 1'b0, "R9 irq0 before not-full");
    // receiver drains
    rd(1, 3'd0, 32'hA0A0_0001, "R1 word A");
    chk(irq[0], 1'b1, "R7 irq0 not-full");
    chk(irq[1], 1'b0, "R9 irq1 masks not-full");
    rd(0, 3'd7, 32'h3, "R7 status u0");
    rd(1, 3'd7, 32'h2, "R7 status u1");
    rd(0, 3'd2, 0, "R2 full flag clear");
    rd(0, 3'd4, 3, "R3 count three");
    rd(1, 3'd0, 32'hB0B0_0002, "R1 word B");
    rd(1, 3'd0, 32'hC0C0_0003, "R1 word C");
    rd(1, 3'd0, 32'hD0D0_0004, "R4 last word not overwritten");
    rd(1, 3'd0, 32'h0, "R5 empty read");
    rd(0, 3'd4, 0, "R5 count stays zero");
    wr(0, 3'd7, 32'h3);
    chk(irq[0], 1'b0, "R8 irq0 cleared");
    // opposite direction
    wr(1, 3'd1, 32'h1234_5678);
    chk(irq[0], 1'b1, "R6 irq0 new msg mb1");
    rd(0, 3'd5, 1, "R3 count mb1");
    rd(0, 3'd7, 32'h4, "R6 bit2 for mb1");
    rd(0, 3'd1, 32'h1234_5678, "R1 mb1 word");
    // wraparound on mb0
    wr(0, 3'd0, 32'h0000_0F01);
    wr(0, 3'd0, 32'h0000_0F02);
    rd(1, 3'd0, 32'h0000_0F01, "R1 wrap F1");
    rd(1, 3'd0, 32'h0000_0F02, "R1 wrap F2");
    for (int i = 0; i < 4; i++) wr(0, 3'd0, 32'h0000_1000 + i);
    rd(0, 3'd2, 1, "R2 full after wrap");
    for (int i = 0; i < 4; i++) rd(1, 3'd0, 32'h0000_1000 + i, "R1 wrap order");
    rd(0, 3'd4, 0, "R3 count drained");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule